// File: doc/BRIEF.md
# Interval Timer with Register Interface

A down-counting interval timer that software drives through four word-sized registers on a simple synchronous bus. Software writes a period, starts the counter, and either gets a single timeout (one-shot) or a periodic one (auto-reload). A level interrupt is raised while the timeout flag is set and the interrupt is enabled. The counter moves only on cycles where the `tick` input is high, so any prescaler sits outside the block.

Registers are chosen by address bits [3:2]:
- index 0 is status: bit 0 is the timeout flag and bit 1 is the running flag.
- index 1 is control: bit 0 is interrupt enable, bit 1 is auto-reload, bit 2 is a start strobe and bit 3 is a stop strobe.
- index 2 is the period.
- index 3 is a read-only view of the live count.

Address bits [1:0] are ignored. Read data appears on `rdata` one cycle after the read, and holds until the next read.

Top module: `ivtimer`

## Requirements
- R1: After reset, all four registers read zero, the counter is halted and `irq` is low.
- R2: A write of any value to status (index 0) clears the timeout flag. The running flag is unchanged by that write.
- R3: A write to control (index 1) stores the whole word, and reading control returns that word. Bit 2 set starts the counter. Bit 3 set stops it. When both are set, the counter ends up stopped.
- R4: A write to period (index 2) stores the value and loads it into the live count at the same clock edge. The snapshot reads it on the next cycle.
- R5: A write to the snapshot (index 3) changes no register and no count.
- R6: While running, the count drops by exactly one on each cycle with `tick` high. It does not change when `tick` is low or when the counter is stopped.
- R7: A tick on a running count of 1 (or 0) is an expiry. It sets the timeout flag. With control bit 1 clear, the counter stops with a count of 0.
- R8: On expiry with control bit 1 set, the count reloads from period and the counter keeps running.
- R9: `irq` is high exactly when the timeout flag and control bit 0 are both set. It follows each register write and each expiry.
- R10: A read returns status as {running, timeout} in bits [1:0], control, period or the live count. The data appears on `rdata` in the cycle after the read.
- R11: Collisions in the same cycle are resolved as follows:
  - An expiry and a status write together leave the timeout flag set.
  - A period write and a tick together load the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable, one decrement per high cycle |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address, bits [3:2] pick the register |
| bus_wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, valid one cycle after a read |
| irq | output | 1 | Level interrupt |

## Verification
The timer is run under three tick patterns:
- `tick` held low separates stored state from counting.
- `tick` high every cycle exposes off-by-one errors at expiry.
- `tick` high every third cycle shows that the count follows ticks and not clocks.

One-shot and auto-reload runs are contrasted by the running flag and the count after expiry. Deliberate collisions place a status write on the expiring tick, and a period write on a counting tick, to pin down the priority rules. Writes to the snapshot and combined start/stop strobes are read back through the register interface to show what they left unchanged.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // control word bit positions (decoded by the counter and interrupt logic)
    localparam int CTRL_IE    = 0;
    localparam int CTRL_CONT  = 1;
    localparam int CTRL_START = 2;
    localparam int CTRL_STOP  = 3;

    // status word bit positions
    localparam int STAT_TO  = 0;
    localparam int STAT_RUN = 1;

    typedef enum logic [1:0] {
        RSEL_STATUS = 2'd0,
        RSEL_CTRL   = 2'd1,
        RSEL_PERIOD = 2'd2,
        RSEL_SNAP   = 2'd3
    } rsel_e;

    typedef struct packed {
        logic  wr_status;
        logic  wr_ctrl;
        logic  wr_period;
        logic  wr_snap;
        logic  rd;
        rsel_e rsel;
    } bus_req_t;

endpackage

// File: rtl/tmr_bus_dec.sv
module tmr_bus_dec
    import tmr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output bus_req_t          req
);
    localparam int IDX_LSB = 2;
    localparam int IDX_MSB = 3;

    logic  hit;
    rsel_e idx;
    logic  unused_lo;

    assign unused_lo = ^addr[IDX_LSB-1:0];
    assign idx       = rsel_e'(addr[IDX_MSB:IDX_LSB]);

    generate
        if (ADDR_W > IDX_MSB + 1) begin : g_wide
            assign hit = sel && (addr[ADDR_W-1:IDX_MSB+1] == '0);
        end else begin : g_exact
            assign hit = sel;
        end
    endgenerate

    always_comb begin
        req           = '0;
        req.rsel      = idx;
        req.rd        = hit && !we;
        req.wr_status = hit && we && (idx == RSEL_STATUS);
        req.wr_ctrl   = hit && we && (idx == RSEL_CTRL);
        req.wr_period = hit && we && (idx == RSEL_PERIOD);
        req.wr_snap   = hit && we && (idx == RSEL_SNAP);
    end

endmodule

// File: rtl/tmr_count.sv
module tmr_count
    import tmr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_status,
    input  logic             wr_ctrl,
    input  logic             wr_period,
    input  logic [WIDTH-1:0] wdata,
    input  logic             cont,
    input  logic [WIDTH-1:0] period,
    output logic [WIDTH-1:0] count,
    output logic             running,
    output logic             timeout
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] count;
        logic             running;
        logic             timeout;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       expire;

    always_comb begin
        st_d   = st_q;
        expire = st_q.running && tick && (st_q.count <= ONE);

        if (st_q.running && tick) begin
            if (expire) begin
                st_d.timeout = 1'b1;
                if (cont) begin
                    st_d.count = period;
                end else begin
                    st_d.count   = '0;
                    st_d.running = 1'b0;
                end
            end else begin
                st_d.count = st_q.count - ONE;
            end
        end

        // a status write clears the flag unless an expiry sets it this cycle
        if (wr_status && !expire) begin
            st_d.timeout = 1'b0;
        end

        // stop is applied after start
        if (wr_ctrl) begin
            if (wdata[CTRL_START]) st_d.running = 1'b1;
            if (wdata[CTRL_STOP])  st_d.running = 1'b0;
        end

        if (wr_period) begin
            st_d.count = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.count;
    assign running = st_q.running;
    assign timeout = st_q.timeout;

    p_decrement_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && count > ONE && !wr_period) |=> (count == $past(count) - ONE));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_period) |=> $stable(count));

    p_oneshot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && count <= ONE && !cont && !wr_ctrl && !wr_period)
        |=> (!running && timeout && count == '0));

    p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && count <= ONE && cont && !wr_ctrl && !wr_period)
        |=> (running && timeout && count == $past(period)));

    p_status_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_status && !(running && tick)) |=> !timeout);

    p_period_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_period |=> (count == $past(wdata)));

    p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CTRL_STOP]) |=> !running);

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  bus_req_t         req,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] count,
    input  logic             running,
    input  logic             timeout,
    output logic [WIDTH-1:0] ctrl,
    output logic [WIDTH-1:0] period,
    output logic [WIDTH-1:0] rdata,
    output logic             irq
);
    typedef struct packed {
        logic [WIDTH-1:0] ctrl;
        logic [WIDTH-1:0] period;
        logic [WIDTH-1:0] rdata;
    } reg_state_t;

    reg_state_t       rg_d, rg_q;
    logic [WIDTH-1:0] status_word;

    always_comb begin
        status_word           = '0;
        status_word[STAT_TO]  = timeout;
        status_word[STAT_RUN] = running;
    end

    always_comb begin
        rg_d = rg_q;
        if (req.wr_ctrl)   rg_d.ctrl   = wdata;
        if (req.wr_period) rg_d.period = wdata;
        if (req.rd) begin
            unique case (req.rsel)
                RSEL_STATUS: rg_d.rdata = status_word;
                RSEL_CTRL:   rg_d.rdata = rg_q.ctrl;
                RSEL_PERIOD: rg_d.rdata = rg_q.period;
                RSEL_SNAP:   rg_d.rdata = count;
                default:     rg_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign ctrl   = rg_q.ctrl;
    assign period = rg_q.period;
    assign rdata  = rg_q.rdata;
    assign irq    = timeout && rg_q.ctrl[CTRL_IE];

    p_ctrl_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req.wr_ctrl |=> (ctrl == $past(wdata)));

    p_rd_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req.rd && req.rsel == RSEL_SNAP) |=> (rdata == $past(count)));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req.rd |=> $stable(rdata));

    p_snap_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req.wr_snap |=> ($stable(ctrl) && $stable(period)));

endmodule

// File: rtl/ivtimer.sv
module ivtimer
    import tmr_pkg::*;
#(
    parameter int WIDTH  = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  rdata,
    output logic              irq
);
    bus_req_t         req;
    logic [WIDTH-1:0] ctrl_w, period_w, count_w;
    logic             running_w, timeout_w;

    tmr_bus_dec #(.ADDR_W(ADDR_W)) u_dec (
        .sel  (bus_sel),
        .we   (bus_we),
        .addr (bus_addr),
        .req  (req)
    );

    tmr_count #(.WIDTH(WIDTH)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .wr_status (req.wr_status),
        .wr_ctrl   (req.wr_ctrl),
        .wr_period (req.wr_period),
        .wdata     (bus_wdata),
        .cont      (ctrl_w[CTRL_CONT]),
        .period    (period_w),
        .count     (count_w),
        .running   (running_w),
        .timeout   (timeout_w)
    );

    tmr_regs #(.WIDTH(WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .wdata   (bus_wdata),
        .count   (count_w),
        .running (running_w),
        .timeout (timeout_w),
        .ctrl    (ctrl_w),
        .period  (period_w),
        .rdata   (rdata),
        .irq     (irq)
    );

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (timeout_w && ctrl_w[CTRL_IE]));

    p_irq_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req.wr_status && !running_w) |=> !irq);

endmodule

// File: tb/ivtimer_bench.sv
module ivtimer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    ivtimer u_ivtimer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rdata(rdata), .irq(irq)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int tick_mode = 0;
    int phase = 0;
    bit cmp_en = 0;

    // behavioural reference state
    logic [31:0] m_cnt = 0, m_ctrl = 0, m_per = 0, m_rd = 0;
    logic        m_run = 0, m_to = 0;

    always @(posedge clk) begin
        logic        ex;
        logic [31:0] n_cnt, n_ctrl, n_per, n_rd;
        logic        n_run, n_to;
        if (!rst_n) begin
            m_cnt = 0; m_ctrl = 0; m_per = 0; m_rd = 0; m_run = 0; m_to = 0;
        end else begin
            n_cnt = m_cnt; n_ctrl = m_ctrl; n_per = m_per; n_rd = m_rd;
            n_run = m_run; n_to = m_to;
            ex = m_run && tick && (m_cnt <= 1);
            if (m_run && tick) begin
                if (ex) begin
                    n_to = 1;
                    if (m_ctrl[1]) n_cnt = m_per;
                    else begin n_cnt = 0; n_run = 0; end
                end else n_cnt = m_cnt - 1;
            end
            if (bus_sel && bus_we) begin
                case (bus_addr[3:2])
                    2'd0: if (!ex) n_to = 0;
                    2'd1: begin
                        n_ctrl = bus_wdata;
                        if (bus_wdata[2]) n_run = 1;
                        if (bus_wdata[3]) n_run = 0;
                    end
                    2'd2: begin n_per = bus_wdata; n_cnt = bus_wdata; end
                    default: ;
                endcase
            end
            if (bus_sel && !bus_we) begin
                case (bus_addr[3:2])
                    2'd0: n_rd = {30'd0, m_run, m_to};
                    2'd1: n_rd = m_ctrl;
                    2'd2: n_rd = m_per;
                    default: n_rd = m_cnt;
                endcase
            end
            m_cnt = n_cnt; m_ctrl = n_ctrl; m_per = n_per; m_rd = n_rd;
            m_run = n_run; m_to = n_to;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    // one bus cycle: compare against the model away from the edge, then drive
    task automatic cyc(input logic s, input logic w, input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        if (cmp_en) begin
            check("R9 irq level vs model", {31'd0, irq}, {31'd0, m_to & m_ctrl[0]});
            check("R10 rdata vs model", rdata, m_rd);
        end
        phase++;
        tick      = (tick_mode == 1) || (tick_mode == 2 && (phase % 3) == 0);
        bus_sel   = s;
        bus_we    = w;
        bus_addr  = a;
        bus_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 32'h0);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cyc(1, 1, a, d);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        cyc(1, 0, a, 32'h0);
        cyc(0, 0, 4'h0, 32'h0);
        v = rdata;
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] a, input logic [31:0] e);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, e);
    endtask

    initial begin
        logic [31:0] snap_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1;

        // R1: reset state
        expect_reg("R1 status after reset", 4'h0, 32'h0);
        expect_reg("R1 control after reset", 4'h4, 32'h0);
        expect_reg("R1 period after reset", 4'h8, 32'h0);
        expect_reg("R1 snapshot after reset", 4'hC, 32'h0);
        check("R1 irq after reset", {31'd0, irq}, 32'h0);

        // R4 period write loads count; R6 counts only with tick
        tick_mode = 0;
        wr(4'h8, 32'd20);
        expect_reg("R4 snapshot after period write", 4'hC, 32'd20);
        wr(4'h4, 32'h4);
        idle(3);
        expect_reg("R6 no tick, count held", 4'hC, 32'd20);
        tick_mode = 1;
        idle(4);
        tick_mode = 0;
        expect_reg("R6 four ticks decrement", 4'hC, 32'd16);
        wr(4'h4, 32'h8);

        // R7 one-shot expiry with interrupt enabled
        wr(4'h8, 32'd5);
        tick_mode = 1;
        wr(4'h4, 32'h5);
        idle(10);
        expect_reg("R7 one-shot status", 4'h1, 32'h1);
        check("R9 irq with flag and enable", {31'd0, irq}, 32'h1);
        expect_reg("R7 one-shot count zero", 4'hC, 32'h0);

        // R2 status write clears flag and irq
        wr(4'h0, 32'hFFFF_FFFF);
        expect_reg("R2 status cleared", 4'h0, 32'h0);
        check("R9 irq low after clear", {31'd0, irq}, 32'h0);

        // R8 continuous mode, tick every third cycle, irq disabled
        tick_mode = 2;
        wr(4'h8, 32'd3);
        wr(4'h4, 32'h6);
        idle(40);
        expect_reg("R8 continuous still running with flag", 4'h0, 32'h3);
        check("R9 irq low while disabled", {31'd0, irq}, 32'h0);
        tick_mode = 0;
        idle(1);
        wr(4'h0, 32'h0);
        expect_reg("R2 running flag kept", 4'h0, 32'h2);

        // R5 snapshot writes ignored
        expect_reg("R10 period readback", 4'h8, 32'd3);
        rd(4'hC, snap_before);
        wr(4'hC, 32'hDEAD_BEEF);
        expect_reg("R5 period untouched", 4'h8, 32'd3);
        expect_reg("R5 control untouched", 4'h4, 32'h6);
        expect_reg("R5 count untouched", 4'hC, snap_before);

        // R3 start and stop strobes
        wr(4'h4, 32'hC);
        expect_reg("R3 start+stop leaves stopped", 4'h0, 32'h0);
        expect_reg("R3 control stores whole word", 4'h4, 32'hC);
        wr(4'h4, 32'h4);
        expect_reg("R3 start runs", 4'h0, 32'h2);
        wr(4'h4, 32'h8);
        expect_reg("R3 stop halts", 4'h0, 32'h0);

        // R11 status write on the expiring tick
        wr(4'h8, 32'd1);
        tick_mode = 1;
        wr(4'h4, 32'h4);
        wr(4'h0, 32'h0);
        expect_reg("R11 expiry beats status clear", 4'h0, 32'h1);

        // R11 period write on a counting tick
        wr(4'h0, 32'h0);
        wr(4'h8, 32'd10);
        wr(4'h4, 32'h6);
        idle(2);
        wr(4'h8, 32'd50);
        expect_reg("R11 period write beats tick", 4'hC, 32'd50);
        idle(60);
        tick_mode = 0;
        idle(2);

        finish_run();
    end

endmodule